// File: doc/BRIEF.md
# Base Integer Subset Instruction Decoder

This block is a purely combinational front-end decoder for 32-bit base integer RISC-V instruction words. It looks at the 5-bit major opcode to classify the word into one of six encoding formats. It builds the sign-extended immediate for that format and breaks out the register indices and function codes. It also tells downstream logic which of those fields actually mean something for the word at hand.

On top of the field decode, it recognises a small instruction subset: the six conditional branches, register-register ADD and immediate ADDI. Each of these raises its own flag. Any word outside the subset raises a single illegal flag, which lets a minimal core trap or stall. The block holds no state, so its outputs follow the input word within the same cycle.

Top module: `rv_subset_decoder`

## Requirements
- R1: `fmt` is one-hot or zero and is selected by instr[6:2] alone. 01100 gives R (bit 0). 00100, 00000 and 11001 give I (bit 1). 01000 gives S (bit 2). 11000 gives B (bit 3). 01101 and 00101 give U (bit 4). 11011 gives J (bit 5). Any other value gives zero.
- R2: When instr[1:0] is not 2'b11, `fmt`, all valid bits and `op` are zero and `illegal` is 1.
- R3: For the I format, `imm` is instr[31:20] sign-extended from instr[31].
- R4: For the S format, `imm` is {instr[31:25], instr[11:7]} sign-extended.
- R5: For the B format, `imm` is {instr[31], instr[7], instr[30:25], instr[11:8], 0} sign-extended, so bit 0 is always 0.
- R6: For the U format, `imm` is {instr[31:12], 12 zero bits}.
- R7: For the J format, `imm` is {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended.
- R8: For the R format and for unrecognised opcodes, `imm` is 0.
- R9: `rd`=instr[11:7], `rs1`=instr[19:15], `rs2`=instr[24:20], `funct3`=instr[14:12] and `funct7`=instr[31:25] are output for every word.
- R10: `rs1_vld` and `funct3_vld` are set for R, I, S and B. `rs2_vld` is set for R, S and B. `funct7_vld` is set for R only. `rd_vld` is set for R, I, U and J.
- R11: In the B format, funct3 selects the branch flag. 000 is BEQ (`op` bit 0), 001 is BNE (bit 1), 100 is BLT (bit 2), 101 is BGE (bit 3), 110 is BLTU (bit 4) and 111 is BGEU (bit 5). Codes 010 and 011 are illegal.
- R12: ADDI (`op` bit 6) requires opcode 00100 and funct3 000, with any upper bits. Other I-format words are illegal.
- R13: ADD (`op` bit 7) requires the R format with funct7 0000000 and funct3 000. Any other R-format word is illegal.
- R14: At most one `op` bit is set, and `illegal` is 1 exactly when none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| fmt | output | 6 | One-hot format: bit0 R, bit1 I, bit2 S, bit3 B, bit4 U, bit5 J |
| imm | output | XLEN | Sign-extended immediate |
| rd | output | 5 | Destination register index |
| rs1 | output | 5 | First source register index |
| rs2 | output | 5 | Second source register index |
| funct3 | output | 3 | Minor function code |
| funct7 | output | 7 | Upper function code |
| rd_vld | output | 1 | rd is meaningful |
| rs1_vld | output | 1 | rs1 is meaningful |
| rs2_vld | output | 1 | rs2 is meaningful |
| funct3_vld | output | 1 | funct3 is meaningful |
| funct7_vld | output | 1 | funct7 is meaningful |
| op | output | 8 | Recognised instruction flags (bit order in R11 to R13) |
| illegal | output | 1 | Word is outside the supported subset |

## Verification
The bench targets the scrambled B and J immediates using offsets that isolate the displaced bits 11 and 12. A decoder that swapped these would report branch targets off by 2 KiB or 4 KiB. It sends SUB and SLTI lookalikes, which share the ADD and ADDI opcodes but differ in funct7 or funct3, so a matcher that ignores those fields would wrongly accept them. It also sends branches with the unused funct3 codes 010 and 011, which a decoder that only masked funct3 bits would misread as BEQ or BNE. Finally, it sweeps every opcode and the three non-base low-bit patterns, which catches a classifier that overlaps formats or ignores instr[1:0].

// File: rtl/rv_subset_dec_pkg.sv
package rv_subset_dec_pkg;

  localparam int OPC_W    = 5;
  localparam int REG_W    = 5;
  localparam int F3_W     = 3;
  localparam int F7_W     = 7;
  localparam int NUM_FMT  = 6;
  localparam int NUM_BR   = 6;
  localparam int NUM_OPS  = NUM_BR + 2;

  // format vector positions
  localparam int FMT_R = 0;
  localparam int FMT_I = 1;
  localparam int FMT_S = 2;
  localparam int FMT_B = 3;
  localparam int FMT_U = 4;
  localparam int FMT_J = 5;

  // op vector positions (branches occupy 0..NUM_BR-1)
  localparam int OP_ADDI = NUM_BR;
  localparam int OP_ADD  = NUM_BR + 1;

  // major opcodes, instr[6:2]
  localparam logic [OPC_W-1:0] OPC_ALU_RR  = 5'b01100;
  localparam logic [OPC_W-1:0] OPC_ALU_IMM = 5'b00100;
  localparam logic [OPC_W-1:0] OPC_LOAD    = 5'b00000;
  localparam logic [OPC_W-1:0] OPC_JMP_REG = 5'b11001;
  localparam logic [OPC_W-1:0] OPC_STORE   = 5'b01000;
  localparam logic [OPC_W-1:0] OPC_BRANCH  = 5'b11000;
  localparam logic [OPC_W-1:0] OPC_UPPER   = 5'b01101;
  localparam logic [OPC_W-1:0] OPC_UPC     = 5'b00101;
  localparam logic [OPC_W-1:0] OPC_JMP     = 5'b11011;

  localparam logic [1:0] BASE_QUAD = 2'b11;

  // funct3 code of the k-th branch flag
  function automatic logic [F3_W-1:0] br_code(input int k);
    logic [F3_W-1:0] c;
    case (k)
      0:       c = 3'b000;
      1:       c = 3'b001;
      2:       c = 3'b100;
      3:       c = 3'b101;
      4:       c = 3'b110;
      default: c = 3'b111;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rvd_format_sel.sv
module rvd_format_sel
  import rv_subset_dec_pkg::*;
(
  input  logic [6:0]         opc_full,
  output logic [NUM_FMT-1:0] fmt
);

  logic                is_base;
  logic [OPC_W-1:0]    major;

  assign is_base = (opc_full[1:0] == BASE_QUAD);
  assign major   = opc_full[6:2];

  always_comb begin
    fmt = '0;
    if (is_base) begin
      case (major)
        OPC_ALU_RR:                       fmt[FMT_R] = 1'b1;
        OPC_ALU_IMM, OPC_LOAD,
        OPC_JMP_REG:                      fmt[FMT_I] = 1'b1;
        OPC_STORE:                        fmt[FMT_S] = 1'b1;
        OPC_BRANCH:                       fmt[FMT_B] = 1'b1;
        OPC_UPPER, OPC_UPC:               fmt[FMT_U] = 1'b1;
        OPC_JMP:                          fmt[FMT_J] = 1'b1;
        default:                          fmt        = '0;
      endcase
    end
  end

endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
  import rv_subset_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]        instr,
  input  logic [NUM_FMT-1:0] fmt,
  output logic [XLEN-1:0]    imm
);

  localparam int EXT_12 = XLEN - 12;
  localparam int EXT_13 = XLEN - 13;
  localparam int EXT_21 = XLEN - 21;
  localparam int EXT_U  = XLEN - 32;

  logic sgn;
  assign sgn = instr[31];

  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

  assign imm_i = {{EXT_12{sgn}}, instr[31:20]};
  assign imm_s = {{EXT_12{sgn}}, instr[31:25], instr[11:7]};
  assign imm_b = {{EXT_13{sgn}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign imm_j = {{EXT_21{sgn}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};

  generate
    if (EXT_U > 0) begin : g_u_wide
      assign imm_u = {{EXT_U{sgn}}, instr[31:12], 12'b0};
    end else begin : g_u_exact
      assign imm_u = {instr[31:12], 12'b0};
    end
  endgenerate

  always_comb begin
    imm = '0;
    if (fmt[FMT_I])      imm = imm_i;
    else if (fmt[FMT_S]) imm = imm_s;
    else if (fmt[FMT_B]) imm = imm_b;
    else if (fmt[FMT_U]) imm = imm_u;
    else if (fmt[FMT_J]) imm = imm_j;
  end

endmodule

// File: rtl/rvd_op_match.sv
module rvd_op_match
  import rv_subset_dec_pkg::*;
(
  input  logic [OPC_W-1:0]   major,
  input  logic [F3_W-1:0]    funct3,
  input  logic [F7_W-1:0]    funct7,
  input  logic [NUM_FMT-1:0] fmt,
  output logic [NUM_OPS-1:0] op
);

  genvar k;
  generate
    for (k = 0; k < NUM_BR; k++) begin : g_branch
      assign op[k] = fmt[FMT_B] && (funct3 == br_code(k));
    end
  endgenerate

  assign op[OP_ADDI] = fmt[FMT_I] && (major == OPC_ALU_IMM) && (funct3 == '0);
  assign op[OP_ADD]  = fmt[FMT_R] && (funct7 == '0) && (funct3 == '0);

endmodule

// File: rtl/rv_subset_decoder.sv
module rv_subset_decoder
  import rv_subset_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]        instr,
  output logic [NUM_FMT-1:0] fmt,
  output logic [XLEN-1:0]    imm,
  output logic [REG_W-1:0]   rd,
  output logic [REG_W-1:0]   rs1,
  output logic [REG_W-1:0]   rs2,
  output logic [F3_W-1:0]    funct3,
  output logic [F7_W-1:0]    funct7,
  output logic               rd_vld,
  output logic               rs1_vld,
  output logic               rs2_vld,
  output logic               funct3_vld,
  output logic               funct7_vld,
  output logic [NUM_OPS-1:0] op,
  output logic               illegal
);

  // raw field slices, present for every word
  assign rd     = instr[11:7];
  assign rs1    = instr[19:15];
  assign rs2    = instr[24:20];
  assign funct3 = instr[14:12];
  assign funct7 = instr[31:25];

  rvd_format_sel u_fmt (
    .opc_full (instr[6:0]),
    .fmt      (fmt)
  );

  rvd_imm_gen #(.XLEN(XLEN)) u_imm (
    .instr (instr),
    .fmt   (fmt),
    .imm   (imm)
  );

  rvd_op_match u_match (
    .major  (instr[6:2]),
    .funct3 (funct3),
    .funct7 (funct7),
    .fmt    (fmt),
    .op     (op)
  );

  // field validity follows the format
  assign rs1_vld    = fmt[FMT_R] | fmt[FMT_I] | fmt[FMT_S] | fmt[FMT_B];
  assign rs2_vld    = fmt[FMT_R] | fmt[FMT_S] | fmt[FMT_B];
  assign funct3_vld = rs1_vld;
  assign funct7_vld = fmt[FMT_R];
  assign rd_vld     = fmt[FMT_R] | fmt[FMT_I] | fmt[FMT_U] | fmt[FMT_J];

  assign illegal = ~|op;

endmodule

// File: rtl/rv_subset_decoder_chk.sv
module rv_subset_decoder_chk
  import rv_subset_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [31:0]        instr,
  input logic [NUM_FMT-1:0] fmt,
  input logic [XLEN-1:0]    imm,
  input logic [F7_W-1:0]    funct7,
  input logic               rd_vld,
  input logic               rs2_vld,
  input logic [NUM_OPS-1:0] op,
  input logic               illegal
);

  always_comb begin
    assert_fmt_onehot_R1: assert ($onehot0(fmt));
    assert_nonbase_R2: assert ((instr[1:0] == BASE_QUAD) || (fmt == '0 && op == '0 && illegal));
    assert_b_lsb_R5: assert (!fmt[FMT_B] || !imm[0]);
    assert_rtype_imm_R8: assert (!fmt[FMT_R] || imm == '0);
    assert_rd_vld_R10: assert (!rd_vld || !(fmt[FMT_S] || fmt[FMT_B]));
    assert_branch_fmt_R11: assert (!(|op[NUM_BR-1:0]) || (fmt[FMT_B] && rs2_vld && !rd_vld));
    assert_addi_R12: assert (!op[OP_ADDI] || (fmt[FMT_I] && instr[6:2] == OPC_ALU_IMM));
    assert_add_R13: assert (!op[OP_ADD] || (fmt[FMT_R] && funct7 == '0));
    assert_op_onehot_R14: assert ($onehot0(op));
    assert_illegal_excl_R14: assert (!(illegal && (|op)));
  end

endmodule

bind rv_subset_decoder rv_subset_decoder_chk #(.XLEN(XLEN)) u_chk (
  .instr   (instr),
  .fmt     (fmt),
  .imm     (imm),
  .funct7  (funct7),
  .rd_vld  (rd_vld),
  .rs2_vld (rs2_vld),
  .op      (op),
  .illegal (illegal)
);

// File: tb/rv_subset_decoder_tb.sv
module rv_subset_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr;
  logic [5:0]  fmt;
  logic [31:0] imm;
  logic [4:0]  rd, rs1, rs2;
  logic [2:0]  funct3;
  logic [6:0]  funct7;
  logic        rd_vld, rs1_vld, rs2_vld, funct3_vld, funct7_vld;
  logic [7:0]  op;
  logic        illegal;

  rv_subset_decoder u_dut (
    .instr(instr), .fmt(fmt), .imm(imm), .rd(rd), .rs1(rs1), .rs2(rs2),
    .funct3(funct3), .funct7(funct7), .rd_vld(rd_vld), .rs1_vld(rs1_vld),
    .rs2_vld(rs2_vld), .funct3_vld(funct3_vld), .funct7_vld(funct7_vld),
    .op(op), .illegal(illegal)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // encoders built from the field layouts in the requirements
  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] b, logic [4:0] a,
                                        logic [2:0] f3, logic [4:0] d, logic [4:0] oc);
    return {f7, b, a, f3, d, oc, 2'b11};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] v, logic [4:0] a, logic [2:0] f3,
                                        logic [4:0] d, logic [4:0] oc);
    return {v, a, f3, d, oc, 2'b11};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] v, logic [4:0] b, logic [4:0] a);
    return {v[11:5], b, a, 3'b010, v[4:0], 5'b01000, 2'b11};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] v, logic [2:0] f3);
    return {v[12], v[10:5], 5'd7, 5'd9, f3, v[4:1], v[11], 5'b11000, 2'b11};
  endfunction
  function automatic logic [31:0] enc_u(logic [19:0] v, logic [4:0] oc);
    return {v, 5'd4, oc, 2'b11};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] v);
    return {v[20], v[10:1], v[11], v[19:12], 5'd1, 5'b11011, 2'b11};
  endfunction

  typedef struct packed {
    logic [31:0] w;
    logic [5:0]  f;
    logic [31:0] im;
    logic [7:0]  o;
    logic        il;
    int          rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3, 5'b01100), 6'b000001, 32'h0, 8'h80, 1'b0, 13}, // R13 ADD
    '{enc_r(7'h20, 5'd2, 5'd1, 3'd0, 5'd3, 5'b01100), 6'b000001, 32'h0, 8'h00, 1'b1, 13}, // R13 SUB
    '{enc_i(12'hFFF, 5'd6, 3'd0, 5'd5, 5'b00100), 6'b000010, 32'hFFFF_FFFF, 8'h40, 1'b0, 12}, // R12
    '{enc_i(12'h7FF, 5'd6, 3'd0, 5'd5, 5'b00100), 6'b000010, 32'h0000_07FF, 8'h40, 1'b0, 3},  // R3
    '{enc_i(12'h005, 5'd6, 3'd2, 5'd5, 5'b00100), 6'b000010, 32'h0000_0005, 8'h00, 1'b1, 12}, // R12
    '{enc_i(12'h800, 5'd6, 3'd0, 5'd5, 5'b00000), 6'b000010, 32'hFFFF_F800, 8'h00, 1'b1, 12}, // R12
    '{enc_s(12'hFF0, 5'd8, 5'd2),                 6'b000100, 32'hFFFF_FFF0, 8'h00, 1'b1, 4},  // R4
    '{enc_b(13'h0010, 3'd0), 6'b001000, 32'h0000_0010, 8'h01, 1'b0, 11}, // R11 BEQ
    '{enc_b(13'h1FFC, 3'd1), 6'b001000, 32'hFFFF_FFFC, 8'h02, 1'b0, 11}, // R11 BNE
    '{enc_b(13'h0800, 3'd4), 6'b001000, 32'h0000_0800, 8'h04, 1'b0, 5},  // R5 bit 11
    '{enc_b(13'h1000, 3'd5), 6'b001000, 32'hFFFF_F000, 8'h08, 1'b0, 5},  // R5 bit 12
    '{enc_b(13'h0FFE, 3'd6), 6'b001000, 32'h0000_0FFE, 8'h10, 1'b0, 11}, // R11 BLTU
    '{enc_b(13'h0002, 3'd7), 6'b001000, 32'h0000_0002, 8'h20, 1'b0, 11}, // R11 BGEU
    '{enc_b(13'h0004, 3'd2), 6'b001000, 32'h0000_0004, 8'h00, 1'b1, 11}, // R11 010
    '{enc_u(20'hABCDE, 5'b01101), 6'b010000, 32'hABCD_E000, 8'h00, 1'b1, 6}, // R6
    '{enc_u(20'h80000, 5'b00101), 6'b010000, 32'h8000_0000, 8'h00, 1'b1, 6}, // R6
    '{enc_j(21'h1FFFFE), 6'b100000, 32'hFFFF_FFFE, 8'h00, 1'b1, 7}, // R7
    '{enc_j(21'h000802), 6'b100000, 32'h0000_0802, 8'h00, 1'b1, 7}, // R7
    '{enc_i(12'h001, 5'd1, 3'd0, 5'd1, 5'b00100) & 32'hFFFF_FFFE,
      6'b000000, 32'h0, 8'h00, 1'b1, 2}, // R2
    '{32'h0000_0073, 6'b000000, 32'h0, 8'h00, 1'b1, 8}  // R8 unknown opcode
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (instr=%h)", req, act, exp, instr);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [4:0] ev;
    int nfmt;
    instr = 32'h0;
    #1;
    // idle word: low bits 00 is not a base instruction (R2)
    chk(fmt == 6'b0 && op == 8'b0, "R2", {24'b0, op}, 32'h0);
    chk(illegal == 1'b1, "R2", {31'b0, illegal}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].w);
      chk(fmt == VECS[i].f, "R1", {26'b0, fmt}, {26'b0, VECS[i].f});
      chk(imm == VECS[i].im, $sformatf("R%0d imm", VECS[i].rq), imm, VECS[i].im);
      chk(op == VECS[i].o, $sformatf("R%0d op", VECS[i].rq), {24'b0, op}, {24'b0, VECS[i].o});
      chk(illegal == VECS[i].il, "R14", {31'b0, illegal}, {31'b0, VECS[i].il});
      // R9 field slices
      chk({funct7, rs2, rs1, funct3, rd} == VECS[i].w[31:7], "R9",
          {7'b0, funct7, rs2, rs1, funct3, rd}, {7'b0, VECS[i].w[31:7]});
      // R10 validity by format: {rd, rs1, rs2, f3, f7}
      ev[4] = VECS[i].f[0] | VECS[i].f[1] | VECS[i].f[4] | VECS[i].f[5];
      ev[3] = VECS[i].f[0] | VECS[i].f[1] | VECS[i].f[2] | VECS[i].f[3];
      ev[2] = VECS[i].f[0] | VECS[i].f[2] | VECS[i].f[3];
      ev[1] = ev[3];
      ev[0] = VECS[i].f[0];
      chk({rd_vld, rs1_vld, rs2_vld, funct3_vld, funct7_vld} == ev, "R10",
          {27'b0, rd_vld, rs1_vld, rs2_vld, funct3_vld, funct7_vld}, {27'b0, ev});
    end

    // R1: sweep all major opcodes; exactly nine classify
    nfmt = 0;
    for (int oc = 0; oc < 32; oc++) begin
      apply({25'h0, oc[4:0], 2'b11});
      if (fmt != 6'b0) nfmt++;
      chk($countones(fmt) <= 1, "R1 onehot", {26'b0, fmt}, 32'h0);
    end
    chk(nfmt == 9, "R1 count", nfmt, 32'd9);

    // R2: ADD with each non-base low pair
    for (int lb = 0; lb < 3; lb++) begin
      apply({7'h0, 5'd2, 5'd1, 3'd0, 5'd3, 5'b01100, lb[1:0]});
      chk(fmt == 6'b0 && illegal && op == 8'b0 && !rd_vld && !rs1_vld,
          "R2 nonbase", {26'b0, fmt}, 32'h0);
    end

    // R11: branch funct3 011 is illegal
    apply(enc_b(13'h0008, 3'd3));
    chk(op == 8'h00 && illegal, "R11 011", {24'b0, op}, 32'h0);

    // R13: ADD with funct3 001 (not ADD)
    apply(enc_r(7'h00, 5'd2, 5'd1, 3'd1, 5'd3, 5'b01100));
    chk(op == 8'h00 && illegal, "R13 f3", {24'b0, op}, 32'h0);

    // R12: ADDI with upper bits that look like funct7 still ADDI
    apply(enc_i(12'h400, 5'd2, 3'd0, 5'd2, 5'b00100));
    chk(op == 8'h40 && imm == 32'h0000_0400, "R12 upper", {24'b0, op}, 32'h40);

    // R3: jump-register word uses I immediate, not ADDI
    apply(enc_i(12'h9AB, 5'd1, 3'd0, 5'd1, 5'b11001));
    chk(imm == 32'hFFFF_F9AB && fmt == 6'b000010 && illegal, "R3 jr", imm, 32'hFFFF_F9AB);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule